// File: doc/BRIEF.md
# Clocked Read-Only Word Store with Selectable Output Enable

This block is a read-only word store, 64K words of 8 bits by default. Each rising clock edge loads the word at the presented address into an output register. A parameter seeds the contents. The contents come from a fixed folding rule of the address instead of a stored array. Because of this, no default elaboration builds a large memory. The full address range can still be read and the expected value of every word can be worked out.

The outputs are gated by an active-low enable. A single configuration bit chooses how that gate works. With the bit at 0, the enable acts combinationally: raising it releases the outputs at once, with no clock edge needed. Lowering it puts the register contents back on the outputs. With the bit at 1, the enable is captured on the rising edge along with the data, so the outputs turn on or off only at a clock edge. The configuration bit is meant to be static. High impedance is shown by a separate drive flag, and the data pins read zero while they are released.

Top module: `rrom_top`

## Requirements
- R1: The word returned for address `a` is `a[7:0] XOR ((a[15:8] * 3) mod 256) XOR SEED`, with SEED defaulting to 0x5A. In general the address is cut into data-width chunks, chunk `i` is multiplied by `2i+1`, and the products are XORed with the seed.
- R2: The output register takes the word of the address present at a rising edge. It holds that word until the next edge, so there is one cycle of latency.
- R3: The enable `rd_en_n` is active low. `rd_drive` is never high while the enable that governs it is high.
- R4: With `cfg_oe_sync` = 0, raising `rd_en_n` clears `rd_drive` without a clock edge. Lowering it sets `rd_drive` and shows the current register contents, also without a clock edge.
- R5: With `cfg_oe_sync` = 1, `rd_drive` equals the inverse of `rd_en_n` as sampled at the most recent rising edge. Enable changes between edges have no effect on the outputs.
- R6: While `rst_n` is low, `rd_drive` is 0 in both modes. The reset clears the output register to 0.
- R7: The output register keeps loading at every edge while the outputs are released. Re-enabling therefore shows the word of the address from the latest edge.
- R8: While `rd_drive` is 1, `rd_data` equals the output register. While it is 0, `rd_data` reads all zeros, which stands for high impedance.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously, released in step with clk |
| rd_addr | input | ADDR_W (16) | Word address |
| rd_en_n | input | 1 | Active-low output enable |
| cfg_oe_sync | input | 1 | Enable mode: 0 combinational, 1 clock-sampled |
| rd_data | output | DATA_W (8) | Registered word, zero while released |
| rd_drive | output | 1 | High when the outputs are driven |

## Verification
The bench builds the block with its default values: a 16-bit address, 8-bit words and seed 0x5A. This gives two address chunks, so the multiplied upper byte reaches the output. Corner addresses such as 0x0000, 0xFFFF and single-byte patterns show that each chunk feeds the result. One vector table is replayed in both enable modes. Directed steps then move the enable between clock edges. This separates the gate that responds at once from the gate that waits for an edge. It also shows that data loaded while the outputs were released appears on re-enable.

// File: rtl/rrom_pkg.sv
package rrom_pkg;
  typedef enum logic {
    OE_COMB    = 1'b0,
    OE_SAMPLED = 1'b1
  } oe_mode_e;

  localparam int DEF_ADDR_W = 16;
  localparam int DEF_DATA_W = 8;
endpackage

// File: rtl/rrom_content.sv
module rrom_content #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter logic [DATA_W-1:0] SEED = DATA_W'(8'h5A)
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] word
);
  localparam int NCH  = (ADDR_W + DATA_W - 1) / DATA_W;
  localparam int PADW = NCH * DATA_W;

  logic [PADW-1:0]   addr_pad;
  logic [DATA_W-1:0] term [NCH];

  assign addr_pad = PADW'(addr);

  // one weighted term per address chunk; odd weights keep each chunk visible
  for (genvar gi = 0; gi < NCH; gi++) begin : g_chunk
    logic [2*DATA_W-1:0] prod;
    assign prod     = addr_pad[gi*DATA_W +: DATA_W] * DATA_W'(2*gi + 1);
    assign term[gi] = prod[DATA_W-1:0];
  end

  always_comb begin
    word = SEED;
    for (int i = 0; i < NCH; i++) word = word ^ term[i];
  end
endmodule

// File: rtl/rrom_word_reg.sv
module rrom_word_reg #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_en,
  input  logic [DATA_W-1:0] d,
  output logic [DATA_W-1:0] q
);
  logic [DATA_W-1:0] q_nxt;

  always_comb begin
    q_nxt = q;
    if (ld_en) q_nxt = d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_nxt;
  end
endmodule

// File: rtl/rrom_oe_ctrl.sv
module rrom_oe_ctrl
  import rrom_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     en_n,
  input  oe_mode_e mode,
  output logic     drive
);
  logic oe_q, oe_nxt;
  logic armed_q;

  assign oe_nxt = ~en_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oe_q    <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      oe_q    <= oe_nxt;
      armed_q <= 1'b1;
    end
  end

  always_comb begin
    if (mode == OE_SAMPLED) drive = oe_q;
    else                    drive = rst_n & ~en_n;
  end

  AST_SAMPLED_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && mode == OE_SAMPLED) |-> (drive == $past(!en_n))); // R5
endmodule

// File: rtl/rrom_top.sv
module rrom_top
  import rrom_pkg::*;
#(
  parameter int ADDR_W = DEF_ADDR_W,
  parameter int DATA_W = DEF_DATA_W,
  parameter logic [DATA_W-1:0] SEED = DATA_W'(8'h5A)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_en_n,
  input  logic              cfg_oe_sync,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_drive
);
  logic [DATA_W-1:0] word_c;
  logic [DATA_W-1:0] word_q;
  logic              past_ok_q;
  oe_mode_e          mode;

  assign mode = oe_mode_e'(cfg_oe_sync);

  rrom_content #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SEED(SEED)) u_content (
    .addr (rd_addr),
    .word (word_c)
  );

  rrom_word_reg #(.DATA_W(DATA_W)) u_wreg (
    .clk   (clk),
    .rst_n (rst_n),
    .ld_en (1'b1),
    .d     (word_c),
    .q     (word_q)
  );

  rrom_oe_ctrl u_oe (
    .clk   (clk),
    .rst_n (rst_n),
    .en_n  (rd_en_n),
    .mode  (mode),
    .drive (rd_drive)
  );

  assign rd_data = rd_drive ? word_q : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok_q <= 1'b0;
    else        past_ok_q <= 1'b1;
  end

  AST_LOAD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok_q |-> (word_q == $past(word_c))); // R2
  AST_COMB_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == OE_COMB && rd_en_n) |-> !rd_drive); // R4
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_drive |-> (rd_data == '0)); // R8
  always_comb begin
    if (!rst_n) AST_RESET_QUIET: assert (!rd_drive); // R6
  end
endmodule

// File: tb/sim_rrom_top.sv
module sim_rrom_top;
  localparam int CLK_P = 10;
  localparam int NV    = 12;
  // {addr[15:0], en_n}
  localparam logic [16:0] VEC [NV] = '{
    {16'h0000, 1'b0}, {16'hFFFF, 1'b0}, {16'h00FF, 1'b0}, {16'hFF00, 1'b0},
    {16'h1234, 1'b1}, {16'h1234, 1'b0}, {16'h0100, 1'b0}, {16'h8001, 1'b0},
    {16'hA5A5, 1'b1}, {16'h5A5A, 1'b0}, {16'h7F80, 1'b0}, {16'hC3E1, 1'b1}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] rd_addr;
  logic        rd_en_n;
  logic        cfg_oe_sync;
  logic [7:0]  rd_data;
  logic        rd_drive;
  int          n_chk = 0;
  int          n_bad = 0;
  bit          done  = 1'b0;

  rrom_top u0 (
    .clk(clk), .rst_n(rst_n), .rd_addr(rd_addr), .rd_en_n(rd_en_n),
    .cfg_oe_sync(cfg_oe_sync), .rd_data(rd_data), .rd_drive(rd_drive)
  );

  always #(CLK_P/2) clk = ~clk;

  function automatic logic [7:0] exp_word(input logic [15:0] a);
    logic [15:0] hi3;
    hi3 = {8'h00, a[15:8]} * 16'd3;
    return a[7:0] ^ hi3[7:0] ^ 8'h5A;
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic mode);
    @(negedge clk);
    rst_n = 1'b0; cfg_oe_sync = mode; rd_en_n = 1'b0; rd_addr = 16'h0000;
    repeat (2) @(negedge clk);
    chk("R6 drive in reset", {7'd0, rd_drive}, 8'h00);
    rst_n = 1'b1;
  endtask

  initial begin
    rst_n = 1'b0; rd_addr = '0; rd_en_n = 1'b1; cfg_oe_sync = 1'b0;
    for (int m = 0; m < 2; m++) begin
      do_reset(m[0]);
      if (m == 0) begin
        #1;
        chk("R6 cleared register", rd_data, 8'h00);
      end
      for (int i = 0; i < NV; i++) begin
        @(negedge clk);
        rd_addr = VEC[i][16:1]; rd_en_n = VEC[i][0];
        @(posedge clk); #2;
        chk("R3 drive vs enable", {7'd0, rd_drive}, {7'd0, ~VEC[i][0]});
        if (!VEC[i][0]) chk("R1 R2 word", rd_data, exp_word(VEC[i][16:1]));
        else            chk("R8 idle zero", rd_data, 8'h00);
      end
    end

    // combinational mode: mid-cycle enable changes
    do_reset(1'b0);
    @(negedge clk); rd_addr = 16'hBEEF; rd_en_n = 1'b0;
    @(posedge clk); #2;
    rd_en_n = 1'b1; #1;
    chk("R4 release without edge", {7'd0, rd_drive}, 8'h00);
    @(negedge clk); rd_addr = 16'h4321;
    @(posedge clk); #2;
    rd_en_n = 1'b0; #1;
    chk("R4 restore without edge", {7'd0, rd_drive}, 8'h01);
    chk("R7 loaded while released", rd_data, exp_word(16'h4321));
    chk("R8 bus equals register", rd_data, exp_word(16'h4321));

    // sampled mode: mid-cycle enable changes wait for an edge
    do_reset(1'b1);
    @(negedge clk); rd_addr = 16'h0F0F; rd_en_n = 1'b0;
    @(posedge clk); #2;
    rd_en_n = 1'b1; #1;
    chk("R5 hold until edge", {7'd0, rd_drive}, 8'h01);
    chk("R5 data held", rd_data, exp_word(16'h0F0F));
    @(posedge clk); #2;
    chk("R5 released at edge", {7'd0, rd_drive}, 8'h00);
    rd_en_n = 1'b0; #1;
    chk("R5 no early restore", {7'd0, rd_drive}, 8'h00);
    @(posedge clk); #2;
    chk("R5 restored at edge", {7'd0, rd_drive}, 8'h01);
    done = 1'b1;
  end

  initial begin
    fork
      begin
        wait (done);
      end
      begin
        repeat (5000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=hung expected=finished");
      end
    join_any
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule